// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the divider settings of a clock synthesizer: a 9-bit feedback multiplier value, a 2-bit output-divider code and a 2-bit test-select code. Two load paths write the same registers. The parallel path is transparent while its active-low strobe is low. It keeps the last value when the strobe returns high.

The serial path has three wires: data, clock and a load strobe. Data shifts into a 14-bit register on each rising serial clock. The frame moves into the divider registers on the rising edge of the load strobe. While the strobe stays high, every serial clock edge passes the new shift contents straight through.

A test output selects one of four sources by the test-select code. It is forced low while the parallel strobe is low. All control inputs are sampled in a single system clock domain. The multiplier value is flagged when it lies outside the lockable window, but it is still loaded.

Top module: `cfg_loader`

## Requirements
- R1: While `pLoadN` is 0, `mVal`/`nVal` follow `mPins`/`nPins` one clock after the pins are sampled.
- R2: After `pLoadN` rises, `mVal`/`nVal` hold the last sampled pin values even when the pins change.
- R3: A serial frame is 14 bits, sent first-to-last as T1, T0, a spare bit, N1, N0, M8 … M0. Each bit is taken on a rising `sClk` while `pLoadN` is 1. A rising `sLoad` copies the frame into `tVal`, `nVal` and `mVal`.
- R4: The spare (third) frame bit has no effect on `mVal`, `nVal` or `tVal`.
- R5: After `sLoad` falls, further serial clocks leave `mVal`, `nVal` and `tVal` unchanged.
- R6: While `sLoad` stays 1, each rising `sClk` updates the registers with the shifted contents. Bit 0 of `mVal` takes the newest data bit.
- R7: With `pLoadN` at 1, `testOut` follows `tVal`. Code 00 drives 0. Code 01 drives `sData`. Code 10 drives `mDivIn`. Code 11 drives `halfOutIn`.
- R8: While `pLoadN` is 0, `testOut` is 0 whatever the value of `tVal`. Parallel loading does not change `tVal`.
- R9: `mOutOfRange` is 1 exactly when `mVal` < 8 or `mVal` > 28. The value is loaded either way.
- R10: After reset, `mVal` is 20, `nVal` is 0, `tVal` is 0 and the shift register is cleared.
- R11: While `pLoadN` is 0, serial clocks do not change the shift register. A later `sLoad` rise loads the frame that was shifted before the parallel phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pLoadN | input | 1 | Parallel load strobe, active low |
| mPins | input | 9 | Parallel multiplier value |
| nPins | input | 2 | Parallel output-divider code |
| sClk | input | 1 | Serial clock, sampled by `clk` |
| sData | input | 1 | Serial data |
| sLoad | input | 1 | Serial load strobe |
| mDivIn | input | 1 | Multiplier divider output for test observation |
| halfOutIn | input | 1 | Half-rate synthesizer output for test observation |
| mVal | output | 9 | Loaded multiplier value |
| nVal | output | 2 | Loaded output-divider code |
| tVal | output | 2 | Loaded test-select code |
| testOut | output | 1 | Test multiplexer output |
| mOutOfRange | output | 1 | Multiplier outside 8..28 |

## Verification
On every cycle, the assertions check four things. A parallel pass captures the pins. Registers stay stable whenever no load strobe is active. Each shift takes the data bit. A serial transfer without a shift copies the frame fields. Bit order across a whole frame, the spare slot being ignored, hold after the strobe falls, and the preserved frame across a parallel phase can only be shown by the bench's scenarios. The test multiplexer sources and the range flag boundaries are also shown only there.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef struct packed {
    logic parPass;
    logic shiftEn;
    logic serXfer;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pLoadN,
  input  logic       sClk,
  input  logic       sLoad,
  output cfgStrobe_t strobe
);
  logic sClkQ, sLoadQ;
  logic sClkRise, sLoadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sClkQ  <= 1'b0;
      sLoadQ <= 1'b0;
    end else begin
      sClkQ  <= sClk;
      sLoadQ <= sLoad;
    end
  end

  assign sClkRise  = sClk & ~sClkQ;
  assign sLoadRise = sLoad & ~sLoadQ;

  always_comb begin
    strobe.parPass = ~pLoadN;
    strobe.shiftEn = pLoadN & sClkRise;
    strobe.serXfer = pLoadN & (sLoadRise | (sLoad & sClkRise));
  end

  // R8 R11
  par_ser_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.parPass, strobe.serXfer}));
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int N_W      = 2,
  parameter int T_W      = 2,
  parameter int MIN_M    = 8,
  parameter int MAX_M    = 28,
  parameter int M_RST    = 20,
  parameter bit REG_TEST = 1'b0
) (
  input  logic           clk,
  input  logic           rstN,
  input  cfgStrobe_t     ctl,
  input  logic           pLoadN,
  input  logic [M_W-1:0] mPins,
  input  logic [N_W-1:0] nPins,
  input  logic           sData,
  input  logic           mDivIn,
  input  logic           halfOutIn,
  output logic [M_W-1:0] mVal,
  output logic [N_W-1:0] nVal,
  output logic [T_W-1:0] tVal,
  output logic           testOut,
  output logic           mOutOfRange
);
  localparam int FW     = T_W + 1 + N_W + M_W;
  localparam int N_LO   = M_W;
  localparam int T_LO   = M_W + N_W + 1;

  logic [FW-1:0]  shReg, shNext;
  logic [M_W-1:0] mReg;
  logic [N_W-1:0] nReg;
  logic [T_W-1:0] tReg;
  logic           testSel;

  assign shNext = ctl.shiftEn ? {shReg[FW-2:0], sData} : shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      mReg  <= M_W'(M_RST);
      nReg  <= '0;
      tReg  <= '0;
    end else begin
      shReg <= shNext;
      if (ctl.parPass) begin
        mReg <= mPins;
        nReg <= nPins;
      end else if (ctl.serXfer) begin
        mReg <= shNext[M_W-1:0];
        nReg <= shNext[N_LO +: N_W];
        tReg <= shNext[T_LO +: T_W];
      end
    end
  end

  always_comb begin
    unique case (tReg[1:0])
      2'b00:   testSel = 1'b0;
      2'b01:   testSel = sData;
      2'b10:   testSel = mDivIn;
      default: testSel = halfOutIn;
    endcase
    if (!pLoadN) testSel = 1'b0;
  end

  generate
    if (REG_TEST) begin : g_testReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) testOut <= 1'b0;
        else       testOut <= testSel;
      end
    end else begin : g_testComb
      assign testOut = testSel;
    end
  endgenerate

  assign mVal        = mReg;
  assign nVal        = nReg;
  assign tVal        = tReg;
  assign mOutOfRange = (int'(mReg) < MIN_M) || (int'(mReg) > MAX_M);

  // R1
  par_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.parPass |=> (mReg == $past(mPins)) && (nReg == $past(nPins)));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.parPass && !ctl.serXfer) |=> $stable({mReg, nReg, tReg}));
  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> shReg[0] == $past(sData));
  // R3
  xfer_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.serXfer && !ctl.shiftEn) |=>
      (mReg == $past(shReg[M_W-1:0])) && (nReg == $past(shReg[N_LO +: N_W]))
      && (tReg == $past(shReg[T_LO +: T_W])));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int T_W   = 2,
  parameter int MIN_M = 8,
  parameter int MAX_M = 28,
  parameter int M_RST = 20
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pLoadN,
  input  logic [M_W-1:0] mPins,
  input  logic [N_W-1:0] nPins,
  input  logic           sClk,
  input  logic           sData,
  input  logic           sLoad,
  input  logic           mDivIn,
  input  logic           halfOutIn,
  output logic [M_W-1:0] mVal,
  output logic [N_W-1:0] nVal,
  output logic [T_W-1:0] tVal,
  output logic           testOut,
  output logic           mOutOfRange
);
  cfgStrobe_t strobe;

  cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pLoadN(pLoadN),
    .sClk(sClk), .sLoad(sLoad), .strobe(strobe)
  );

  cfg_datapath #(
    .M_W(M_W), .N_W(N_W), .T_W(T_W), .MIN_M(MIN_M), .MAX_M(MAX_M),
    .M_RST(M_RST), .REG_TEST(1'b0)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(strobe), .pLoadN(pLoadN),
    .mPins(mPins), .nPins(nPins), .sData(sData),
    .mDivIn(mDivIn), .halfOutIn(halfOutIn),
    .mVal(mVal), .nVal(nVal), .tVal(tVal),
    .testOut(testOut), .mOutOfRange(mOutOfRange)
  );
endmodule

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pLoadN = 1'b1;
  logic [8:0] mPins = '0;
  logic [1:0] nPins = '0;
  logic       sClk = 1'b0, sData = 1'b0, sLoad = 1'b0;
  logic       mDivIn = 1'b0, halfOutIn = 1'b0;
  logic [8:0] mVal;
  logic [1:0] nVal, tVal;
  logic       testOut, mOutOfRange;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  cfg_loader u0 (
    .clk(clk), .rstN(rstN), .pLoadN(pLoadN), .mPins(mPins), .nPins(nPins),
    .sClk(sClk), .sData(sData), .sLoad(sLoad), .mDivIn(mDivIn),
    .halfOutIn(halfOutIn), .mVal(mVal), .nVal(nVal), .tVal(tVal),
    .testOut(testOut), .mOutOfRange(mOutOfRange)
  );

  // frame bit order (MSB first): T1 T0 spare N1 N0 M8..M0
  localparam logic [13:0] FRAMES [6] = '{
    {2'b00, 1'b0, 2'b01, 9'd20},
    {2'b00, 1'b1, 2'b01, 9'd20},
    {2'b10, 1'b0, 2'b11, 9'd8},
    {2'b01, 1'b1, 2'b10, 9'd28},
    {2'b11, 1'b0, 2'b00, 9'd300},
    {2'b00, 1'b1, 2'b10, 9'd3}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shiftBit(logic b);
    sData = b; sClk = 1'b1; tick();
    sClk = 1'b0; tick();
  endtask

  task automatic sendFrame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) shiftBit(f[i]);
    sLoad = 1'b1; tick();
    sLoad = 1'b0; tick();
  endtask

  function automatic logic rangeBad(logic [8:0] m);
    return (m < 9'd8) || (m > 9'd28);
  endfunction

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [8:0] keepM;
    logic [13:0] f;
    tick(); tick();
    rstN = 1'b1; tick();
    // R10 reset state
    chk("R10 mVal", mVal, 20);
    chk("R10 nVal", nVal, 0);
    chk("R10 tVal", tVal, 0);
    chk("R10 testOut", testOut, 0);
    chk("R9 flag at reset", mOutOfRange, 0);

    // R3 R4 R9 serial frames from table
    for (int v = 0; v < 6; v++) begin
      f = FRAMES[v];
      sendFrame(f);
      chk("R3 mVal", mVal, f[8:0]);
      chk("R3 nVal", nVal, f[10:9]);
      chk("R3 tVal", tVal, f[13:12]);
      chk("R9 flag", mOutOfRange, rangeBad(f[8:0]));
    end
    // R4 spare slot: frames 0 and 1 differ only there
    sendFrame(FRAMES[1]);
    keepM = mVal;
    sendFrame(FRAMES[0]);
    chk("R4 spare ignored", {tVal, nVal, mVal}, {2'b00, 2'b01, keepM});

    // R5 hold after strobe falls
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1);
    chk("R5 mVal held", mVal, 20);
    chk("R5 nVal held", nVal, 1);

    // R6 pass-through while strobe high; shift reg now = FRAMES[0] shifted by 101
    f = {FRAMES[0][10:0], 3'b101};
    sLoad = 1'b1; tick();
    chk("R6 load on rise", mVal, f[8:0]);
    shiftBit(1'b0);
    f = {f[12:0], 1'b0};
    chk("R6 pass bit0", mVal, f[8:0]);
    shiftBit(1'b1);
    f = {f[12:0], 1'b1};
    chk("R6 pass bit1", mVal, f[8:0]);
    chk("R6 nVal", nVal, f[10:9]);
    sLoad = 1'b0; tick();

    // R7 test multiplexer
    sendFrame({2'b01, 1'b0, 2'b00, 9'd20});
    sData = 1'b1; tick();
    chk("R7 code01 hi", testOut, 1);
    sData = 1'b0; tick();
    chk("R7 code01 lo", testOut, 0);
    sendFrame({2'b10, 1'b0, 2'b00, 9'd20});
    mDivIn = 1'b1; tick();
    chk("R7 code10 hi", testOut, 1);
    mDivIn = 1'b0; tick();
    chk("R7 code10 lo", testOut, 0);
    sendFrame({2'b00, 1'b0, 2'b00, 9'd20});
    sData = 1'b1; mDivIn = 1'b1; halfOutIn = 1'b1; tick();
    chk("R7 code00", testOut, 0);
    sData = 1'b0; mDivIn = 1'b0;
    sendFrame({2'b11, 1'b0, 2'b00, 9'd20});
    chk("R7 code11 hi", testOut, 1);
    halfOutIn = 1'b0; tick();
    chk("R7 code11 lo", testOut, 0);
    halfOutIn = 1'b1;

    // R1 R8 parallel pass-through
    mPins = 9'd25; nPins = 2'd3; pLoadN = 1'b0; tick();
    chk("R1 mVal", mVal, 25);
    chk("R1 nVal", nVal, 3);
    chk("R8 testOut forced", testOut, 0);
    mPins = 9'd13; tick();
    chk("R1 follow", mVal, 13);
    chk("R8 tVal kept", tVal, 3);
    // R2 capture
    mPins = 9'd17; nPins = 2'd2; tick();
    pLoadN = 1'b1; tick();
    mPins = 9'd5; nPins = 2'd1; tick();
    chk("R2 mVal held", mVal, 17);
    chk("R2 nVal held", nVal, 2);
    chk("R8 testOut released", testOut, 1);

    // R9 boundaries via parallel path
    pLoadN = 1'b0;
    mPins = 9'd7;  tick(); chk("R9 m=7", {mOutOfRange, mVal}, {1'b1, 9'd7});
    mPins = 9'd8;  tick(); chk("R9 m=8", {mOutOfRange, mVal}, {1'b0, 9'd8});
    mPins = 9'd28; tick(); chk("R9 m=28", {mOutOfRange, mVal}, {1'b0, 9'd28});
    mPins = 9'd29; tick(); chk("R9 m=29", {mOutOfRange, mVal}, {1'b1, 9'd29});
    pLoadN = 1'b1; tick();

    // R11 serial ignored during parallel phase
    f = {2'b10, 1'b0, 2'b01, 9'd22};
    for (int i = 13; i >= 0; i--) shiftBit(f[i]);
    pLoadN = 1'b0; mPins = 9'd9; tick();
    shiftBit(1'b1); shiftBit(1'b1);
    sLoad = 1'b1; tick(); sLoad = 1'b0; tick();
    chk("R11 parallel wins", mVal, 9);
    pLoadN = 1'b1; tick();
    sLoad = 1'b1; tick(); sLoad = 1'b0; tick();
    chk("R11 frame kept m", mVal, 22);
    chk("R11 frame kept t", tVal, 2);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule